// File: doc/BRIEF.md
# Receive Output-Enable Controller

This block decides when the receive side of a parallel interface drives its pins. It runs on the receive character clock. On each rising edge it samples an active-low chip enable and an active-high receive enable. It produces two registered output-enable signals. The first, `flag_oe`, enables the receive FIFO status flag drivers. The second, `data_oe`, enables the receive data, command and code-violation drivers. A pad ring or a simulation tristate wrapper uses each enable to choose between driving a pin and leaving it at high impedance.

The flag drivers simply follow the sampled chip enable. The data drivers are turned on only by a fresh low-to-high edge of the receive enable, and only when that edge is sampled while the chip enable is low. Once on, the data drivers stay on until the receive enable is sampled low, whatever the chip enable does meanwhile. An asynchronous active-low master reset turns both enables off.

Top module: `rx_oe_ctrl`

## Requirements
- R1: While `rst_n` is low, `flag_oe` and `data_oe` are both 0. Reset also records the previous receive-enable sample as 1.
- R2: After each rising clock edge out of reset, `flag_oe` equals 1 if `ce_n` was sampled 0 at that edge, and 0 if it was sampled 1.
- R3: `data_oe` becomes 1 after an edge where three conditions all hold: `rx_en` is sampled 1, the previous sample of `rx_en` was 0, and `ce_n` is sampled 0 at that same edge.
- R4: `data_oe` becomes 0 after any edge at which `rx_en` is sampled 0.
- R5: While `rx_en` keeps being sampled 1, `data_oe` keeps its value; changes of `ce_n` do not alter it.
- R6: A low-to-high edge of `rx_en` sampled while `ce_n` is 1 leaves `data_oe` at 0. A later fall of `ce_n` while `rx_en` stays high also leaves `data_oe` at 0.
- R7: If `rx_en` is held at 1 through the release of reset, `data_oe` stays 0 until `rx_en` has been sampled 0 and then 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive character clock; all sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| rx_en | input | 1 | Receive output enable request, active high |
| flag_oe | output | 1 | Drive enable for the receive FIFO status flags |
| data_oe | output | 1 | Drive enable for the receive data, command and violation pins |

## Verification
The assertions assume that `ce_n` and `rx_en` are synchronous to `clk` and stable around its rising edge. They also assume that reset is held low for at least one full clock period, so that every register has a defined value before the first edge that is checked. The bench changes the inputs only on falling edges of the clock. It holds reset across several edges, and one reset release is done with `rx_en` already high to exercise R7. After the directed cases, random sequences are applied with a biased mix of chip-enable and receive-enable values, so that enable edges occur under both chip-enable states.

// File: rtl/rx_oe_ctrl.sv
module rx_oe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rx_en,
  output logic flag_oe,
  output logic data_oe
);

  logic en_prev;
  logic turn_on;

  assign turn_on = rx_en && !en_prev && !ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_oe <= 1'b0;
      data_oe <= 1'b0;
      en_prev <= 1'b1;
    end else begin
      flag_oe <= !ce_n;
      en_prev <= rx_en;
      if (!rx_en)
        data_oe <= 1'b0;
      else if (turn_on)
        data_oe <= 1'b1;
    end
  end

endmodule

module rx_oe_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic rx_en,
  input logic flag_oe,
  input logic data_oe
);

  a_r2_flag_follows_ce: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_oe == !$past(ce_n)));

  a_r4_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !data_oe);

  a_r3_on_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> ($past(rx_en) && !$past(ce_n)));

  a_r5_hold_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && rx_en) |=> data_oe);

  a_r6_no_on_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_oe && rx_en) |=> (!data_oe || !$past(ce_n)));

endmodule

bind rx_oe_ctrl rx_oe_ctrl_chk chk_i (.*);

// File: tb/rx_oe_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_oe_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1;
  logic rx_en = 1'b0;
  logic flag_oe, data_oe;

  int checks = 0;
  int errors = 0;

  logic m_flag, m_data, m_prev;

  always #2.5 clk = ~clk;

  rx_oe_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rx_en(rx_en),
    .flag_oe(flag_oe), .data_oe(data_oe)
  );

  function automatic logic next_data(logic cur, logic prev, logic en, logic cen);
    if (!en) return 1'b0;
    if (!prev && !cen) return 1'b1;
    return cur;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_flag = 1'b0; m_data = 1'b0; m_prev = 1'b1;
  endtask

  task automatic step(logic cen, logic en, string ftag, string dtag);
    ce_n = cen; rx_en = en;
    @(posedge clk);
    m_data = next_data(m_data, m_prev, en, cen);
    m_flag = !cen;
    m_prev = en;
    @(negedge clk);
    check(ftag, flag_oe, m_flag);
    check(dtag, data_oe, m_data);
  endtask

  task automatic do_reset(logic en);
    rst_n = 1'b0; ce_n = 1'b0; rx_en = en;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", flag_oe, 1'b0);
    check("R1", data_oe, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset(1'b0);
    step(1'b1, 1'b0, "R2", "R4");
    step(1'b0, 1'b0, "R2", "R4");
    step(1'b0, 1'b1, "R2", "R3");
    check("R3", data_oe, 1'b1);
    step(1'b1, 1'b1, "R2", "R5");
    step(1'b0, 1'b1, "R2", "R5");
    check("R5", data_oe, 1'b1);
    step(1'b1, 1'b0, "R2", "R4");
    check("R4", data_oe, 1'b0);
    step(1'b1, 1'b1, "R2", "R6");
    step(1'b0, 1'b1, "R2", "R6");
    step(1'b0, 1'b1, "R2", "R6");
    check("R6", data_oe, 1'b0);
    do_reset(1'b1);
    step(1'b0, 1'b1, "R2", "R7");
    step(1'b0, 1'b1, "R2", "R7");
    check("R7", data_oe, 1'b0);
    step(1'b0, 1'b0, "R2", "R7");
    step(1'b0, 1'b1, "R2", "R7");
    check("R7", data_oe, 1'b1);
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic c, e;
      c = ($urandom % 3) == 0;
      e = ($urandom % 4) != 0;
      step(c, e, "R2", e ? "R3" : "R4");
      if (i % 1000 == 999) begin
        do_reset(logic'($urandom % 2));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule